// File: doc/BRIEF.md
# Lockout Authentication Stream Sequencer

This block is the lock half of a two-chip lockout handshake carried on two bidirectional data lines. After reset it gives the key chip one reset pulse and then waits briefly. It then sends a four-bit stream selector serially on line 0. After that it runs an endless series of passes. In each bit slot it drives bit 0 of one lock-seed nibble and samples the bit the key returns. It compares that returned bit with its own model of the key seed, and a single disagreement marks the key as invalid until the next reset.

The block does no seed arithmetic itself. When a pass ends, it asks an external mangler for three update operations through a request/acknowledge handshake. It presents both seed vectors and takes the replacements back on each acknowledge. Nibble 7 of the new key-model seed then sets two things for the next pass: which line transmits, and which position the pass starts from. On the first pass, the bit received at the detection position identifies the key type. This controls a 50 Hz / 60 Hz region flag and completes the one key-model nibble that is unknown at reset.

Top module: `lockout_stream_seq`

## Requirements
- R1: While `rst_n` is low, both output enables, `slave_rst`, `mangle_req`, `key_known`, `key_50hz` and `key_invalid` are 0.
- R2: Starting at the first clock after reset release, `slave_rst` is high for exactly SLV_CYC cycles. GAP_CYC cycles follow in which neither line is driven. No data line is driven while `slave_rst` is high.
- R3: The stream selector is key-model nibble 1, sent on line 0 in bit order 3, 0, 1, 2. Each bit lasts BIT_CYC cycles. A 1 bit drives the line high for the first PULSE_CYC cycles of its slot, and the line is low otherwise. Throughout this phase `line0_oe`=1 and `line1_oe`=0.
- R4: In a data slot of BIT_CYC cycles, exactly one line is enabled. Its value is bit 0 of lock nibble p for the first PULSE_CYC cycles and 0 for the rest of the slot. The first pass runs positions 1 to 15, with line 1 sending and line 0 receiving.
- R5: Seed vectors pack nibble p at bits [4p-4 +: 4]. After reset the lock seed holds, from position 1 up: B,1,4,F,4,B,5,7,F,D,6,1,E,9,8. The key model is set by parameter; its default is F,0,A,1,8,5,F,1,1,E,1,0,D,E,C.
- R6: The received bit is sampled in the last driven cycle of its slot. On the first pass, the bit sampled at position 2 sets `key_known`. A 1 selects 60 Hz (`key_50hz`=0) and writes 9 into key-model nibble 2. A 0 selects 50 Hz (`key_50hz`=1) and writes 6 into that nibble.
- R7: After the first pass, the key type and `key_50hz` never change until reset.
- R8: `key_invalid` is set from the cycle after a sampled bit differs from bit 0 of the key-model nibble at that position. It stays set until reset.
- R9: After position 15, `mangle_req` rises and stays high until exactly three `mangle_ack` cycles have occurred. Each acknowledge replaces both seeds with `mangle_lock_i`/`mangle_key_i`. Both line values are 0 while the request is pending.
- R10: If bit 0 of key-model nibble 7 is 1 after the third update, line 0 sends and line 1 receives for the next pass. If it is 0, line 1 sends and line 0 receives.
- R11: The next pass starts at position 1 when key-model nibble 7 is 0. Otherwise it starts at the position equal to its value, and it always ends at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line0_in | input | 1 | Sampled level of data line 0 |
| line1_in | input | 1 | Sampled level of data line 1 |
| line0_out | output | 1 | Drive value for line 0 |
| line0_oe | output | 1 | Output enable for line 0 |
| line1_out | output | 1 | Drive value for line 1 |
| line1_oe | output | 1 | Output enable for line 1 |
| slave_rst | output | 1 | Reset pulse to the key chip |
| mangle_req | output | 1 | Seed update request |
| mangle_ack | input | 1 | One pulse per completed update |
| mangle_lock_o | output | SEED_N*NIB_W | Current lock seed |
| mangle_key_o | output | SEED_N*NIB_W | Current key-model seed |
| mangle_lock_i | input | SEED_N*NIB_W | Updated lock seed |
| mangle_key_i | input | SEED_N*NIB_W | Updated key-model seed |
| key_known | output | 1 | Key type has been identified |
| key_50hz | output | 1 | Identified key is the 50 Hz type |
| key_invalid | output | 1 | A returned bit has disagreed |

## Verification
The bench uses a selector value whose bits differ between the specified order and the natural order. A design that sent the bits in natural order, or pulsed them for the whole slot, would fail at a specific cycle.

On the second pass, the returned bit at position 2 is the opposite of the bit seen on the first pass. A design that re-detected the key type would flip the region flag, and one that compared against a stale nibble would raise the invalid flag.

Three updates drive nibble 7 to 0, to an odd value and to an even non-zero value, which covers the restart, the line swap and the mid-seed resume. During these passes the non-receiving line always carries the inverse of the expected bit, so a design that read the wrong line would be flagged. A single corrupted bit checks that the invalid flag rises one cycle after the sample and survives the following pass.

// File: rtl/lss_pkg.sv
package lss_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_SLV,
      ST_GAP,
      ST_ID,
      ST_RUN,
      ST_MANGLE
   } lss_state_e;

   // nibble written into the key model after type detection
   localparam logic [3:0] TYPE60_NIB = 4'h9;
   localparam logic [3:0] TYPE50_NIB = 4'h6;

   // selector transmission order: slot k sends this bit of the selector
   function automatic logic [1:0] id_order(input logic [1:0] slot);
      case (slot)
         2'd0:    id_order = 2'd3;
         2'd1:    id_order = 2'd0;
         2'd2:    id_order = 2'd1;
         default: id_order = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/lss_cycle_cnt.sv
module lss_cycle_cnt #(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         last
);

   assign last = (count == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr || last)
         count <= '0;
      else
         count <= count + 1'b1;
   end

endmodule

// File: rtl/lss_seed_bank.sv
module lss_seed_bank #(
   parameter int unsigned NIB_W  = 4,
   parameter int unsigned SEED_N = 15,
   parameter logic [SEED_N*NIB_W-1:0] INIT = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_en,
   input  logic [SEED_N*NIB_W-1:0] load_vec,
   input  logic                    patch_en,
   input  logic [NIB_W-1:0]        patch_pos,
   input  logic [NIB_W-1:0]        patch_val,
   input  logic [NIB_W-1:0]        rd_pos,
   output logic [NIB_W-1:0]        rd_nib,
   output logic [SEED_N*NIB_W-1:0] vec_q
);

   logic [NIB_W-1:0] nib_q [SEED_N];

   for (genvar i = 0; i < SEED_N; i++) begin : g_nib
      localparam logic [NIB_W-1:0] POS = NIB_W'(i + 1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            nib_q[i] <= INIT[i*NIB_W +: NIB_W];
         else if (load_en)
            nib_q[i] <= load_vec[i*NIB_W +: NIB_W];
         else if (patch_en && patch_pos == POS)
            nib_q[i] <= patch_val;
      end

      assign vec_q[i*NIB_W +: NIB_W] = nib_q[i];
   end

   always_comb begin
      rd_nib = '0;
      for (int i = 0; i < SEED_N; i++)
         if (rd_pos == NIB_W'(i + 1))
            rd_nib = nib_q[i];
   end

endmodule

// File: rtl/lss_line_port.sv
module lss_line_port (
   input  logic mode_id,
   input  logic mode_data,
   input  logic dir,
   input  logic bit_val,
   input  logic line0_in,
   input  logic line1_in,
   output logic line0_out,
   output logic line0_oe,
   output logic line1_out,
   output logic line1_oe,
   output logic rx_bit
);

   logic drive0, drive1;

   assign drive0    = mode_id | (mode_data & dir);
   assign drive1    = mode_data & ~dir;
   assign line0_oe  = drive0;
   assign line1_oe  = drive1;
   assign line0_out = bit_val & drive0;
   assign line1_out = bit_val & drive1;
   assign rx_bit    = dir ? line1_in : line0_in;

endmodule

// File: rtl/lockout_stream_seq.sv
module lockout_stream_seq
   import lss_pkg::*;
#(
   parameter int unsigned NIB_W     = 4,
   parameter int unsigned SEED_N    = 15,
   parameter int unsigned BIT_CYC   = 15,
   parameter int unsigned PULSE_CYC = 3,
   parameter int unsigned SLV_CYC   = 4,
   parameter int unsigned GAP_CYC   = 16,
   parameter int unsigned DET_POS   = 2,
   parameter int unsigned SEL_POS   = 7,
   parameter logic [SEED_N*NIB_W-1:0] LOCK_INIT = 60'h89E16DF75B4F41B,
   parameter logic [SEED_N*NIB_W-1:0] KEY_INIT  = 60'hCED01E11F581A0F
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    line0_in,
   input  logic                    line1_in,
   output logic                    line0_out,
   output logic                    line0_oe,
   output logic                    line1_out,
   output logic                    line1_oe,
   output logic                    slave_rst,
   output logic                    mangle_req,
   input  logic                    mangle_ack,
   output logic [SEED_N*NIB_W-1:0] mangle_lock_o,
   output logic [SEED_N*NIB_W-1:0] mangle_key_o,
   input  logic [SEED_N*NIB_W-1:0] mangle_lock_i,
   input  logic [SEED_N*NIB_W-1:0] mangle_key_i,
   output logic                    key_known,
   output logic                    key_50hz,
   output logic                    key_invalid
);

   localparam int unsigned MAXC = (BIT_CYC > SLV_CYC)
                                  ? ((BIT_CYC > GAP_CYC) ? BIT_CYC : GAP_CYC)
                                  : ((SLV_CYC > GAP_CYC) ? SLV_CYC : GAP_CYC);
   localparam int unsigned CW   = $clog2(MAXC + 1);
   localparam logic [NIB_W-1:0] LAST_POS = NIB_W'(SEED_N);
   localparam logic [NIB_W-1:0] DPOS     = NIB_W'(DET_POS);

   if (NIB_W < 4)
      $error("NIB_W must be at least 4");
   if ((1 << NIB_W) - 1 != SEED_N)
      $error("SEED_N must equal 2**NIB_W - 1");
   if (PULSE_CYC == 0 || PULSE_CYC >= BIT_CYC)
      $error("PULSE_CYC must lie in 1..BIT_CYC-1");
   if (SLV_CYC == 0 || GAP_CYC == 0)
      $error("SLV_CYC and GAP_CYC must be non-zero");
   if (DET_POS < 1 || DET_POS > SEED_N || SEL_POS < 1 || SEL_POS > SEED_N)
      $error("DET_POS and SEL_POS must be valid seed positions");

   lss_state_e       st_q, st_d;
   logic [CW-1:0]    cnt, lim;
   logic             cnt_last;
   logic [1:0]       idb_q;
   logic [NIB_W-1:0] pos_q;
   logic             first_q, dir_q;
   logic [1:0]       mcnt_q;
   logic             known_q, hz_q, inv_q;

   logic [SEED_N*NIB_W-1:0] lock_vec, key_vec;
   logic [NIB_W-1:0] lock_nib, key_nib, sel_nib, det_val;
   logic             rx_bit, send_bit, id_bit, pulse_win;
   logic             sample, detect, ack_ok, mangle_done;

   // ---------------- phase counter ----------------
   always_comb begin
      case (st_q)
         ST_SLV:         lim = CW'(SLV_CYC - 1);
         ST_GAP:         lim = CW'(GAP_CYC - 1);
         ST_ID, ST_RUN:  lim = CW'(BIT_CYC - 1);
         default:        lim = '0;
      endcase
   end

   lss_cycle_cnt #(.W(CW)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_d != st_q),
      .limit (lim),
      .count (cnt),
      .last  (cnt_last)
   );

   assign pulse_win   = (cnt < CW'(PULSE_CYC));
   assign sample      = (st_q == ST_RUN) && (cnt == CW'(PULSE_CYC - 1));
   assign detect      = sample && first_q && (pos_q == DPOS);
   assign ack_ok      = (st_q == ST_MANGLE) && mangle_ack;
   assign mangle_done = ack_ok && (mcnt_q == 2'd2);
   assign sel_nib     = mangle_key_i[(SEL_POS-1)*NIB_W +: NIB_W];
   assign det_val     = rx_bit ? NIB_W'(TYPE60_NIB) : NIB_W'(TYPE50_NIB);

   // ---------------- state sequencing ----------------
   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_BOOT:   st_d = ST_SLV;
         ST_SLV:    if (cnt_last) st_d = ST_GAP;
         ST_GAP:    if (cnt_last) st_d = ST_ID;
         ST_ID:     if (cnt_last && idb_q == 2'd3) st_d = ST_RUN;
         ST_RUN:    if (cnt_last && pos_q == LAST_POS) st_d = ST_MANGLE;
         ST_MANGLE: if (mangle_done) st_d = ST_RUN;
         default:   st_d = ST_BOOT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_BOOT;
         idb_q   <= '0;
         pos_q   <= NIB_W'(1);
         first_q <= 1'b1;
         dir_q   <= 1'b0;
         mcnt_q  <= '0;
         known_q <= 1'b0;
         hz_q    <= 1'b0;
         inv_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_ID && cnt_last)
            idb_q <= idb_q + 1'b1;
         if (detect) begin
            known_q <= 1'b1;
            hz_q    <= ~rx_bit;
         end else if (sample && rx_bit != key_nib[0]) begin
            inv_q <= 1'b1;
         end
         if (st_q == ST_RUN && cnt_last) begin
            if (pos_q == LAST_POS)
               first_q <= 1'b0;
            else
               pos_q <= pos_q + 1'b1;
         end
         if (ack_ok) begin
            if (mangle_done) begin
               mcnt_q <= '0;
               dir_q  <= sel_nib[0];
               pos_q  <= (sel_nib == '0) ? NIB_W'(1) : sel_nib;
            end else begin
               mcnt_q <= mcnt_q + 1'b1;
            end
         end
      end
   end

   // ---------------- seed storage ----------------
   lss_seed_bank #(.NIB_W(NIB_W), .SEED_N(SEED_N), .INIT(LOCK_INIT)) i_lock_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (ack_ok),
      .load_vec  (mangle_lock_i),
      .patch_en  (1'b0),
      .patch_pos ('0),
      .patch_val ('0),
      .rd_pos    (pos_q),
      .rd_nib    (lock_nib),
      .vec_q     (lock_vec)
   );

   lss_seed_bank #(.NIB_W(NIB_W), .SEED_N(SEED_N), .INIT(KEY_INIT)) i_key_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (ack_ok),
      .load_vec  (mangle_key_i),
      .patch_en  (detect),
      .patch_pos (DPOS),
      .patch_val (det_val),
      .rd_pos    (pos_q),
      .rd_nib    (key_nib),
      .vec_q     (key_vec)
   );

   // ---------------- line drive ----------------
   assign id_bit = key_vec[id_order(idb_q)];

   always_comb begin
      case (st_q)
         ST_ID:   send_bit = id_bit & pulse_win;
         ST_RUN:  send_bit = lock_nib[0] & pulse_win;
         default: send_bit = 1'b0;
      endcase
   end

   lss_line_port i_port (
      .mode_id   (st_q == ST_ID),
      .mode_data ((st_q == ST_RUN) || (st_q == ST_MANGLE)),
      .dir       (dir_q),
      .bit_val   (send_bit),
      .line0_in  (line0_in),
      .line1_in  (line1_in),
      .line0_out (line0_out),
      .line0_oe  (line0_oe),
      .line1_out (line1_out),
      .line1_oe  (line1_oe),
      .rx_bit    (rx_bit)
   );

   assign slave_rst     = (st_q == ST_SLV);
   assign mangle_req    = (st_q == ST_MANGLE);
   assign mangle_lock_o = lock_vec;
   assign mangle_key_o  = key_vec;
   assign key_known     = known_q;
   assign key_50hz      = hz_q;
   assign key_invalid   = inv_q;

endmodule

// File: rtl/lss_checker.sv
module lss_checker (
   input logic clk,
   input logic rst_n,
   input logic line0_oe,
   input logic line1_oe,
   input logic line0_out,
   input logic line1_out,
   input logic slave_rst,
   input logic mangle_req,
   input logic mangle_ack,
   input logic key_known,
   input logic key_50hz,
   input logic key_invalid
);

   // R4
   lines_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(line0_oe && line1_oe));

   // R2
   slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slave_rst |-> (!line0_oe && !line1_oe));

   // R8
   invalid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_invalid |=> key_invalid);

   // R7
   type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_known |=> (key_known && $stable(key_50hz)));

   // R9
   mangle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mangle_req |-> (!line0_out && !line1_out));

   // R9
   mangle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mangle_req) |-> $past(mangle_ack));

endmodule

bind lockout_stream_seq lss_checker i_lss_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line0_oe    (line0_oe),
   .line1_oe    (line1_oe),
   .line0_out   (line0_out),
   .line1_out   (line1_out),
   .slave_rst   (slave_rst),
   .mangle_req  (mangle_req),
   .mangle_ack  (mangle_ack),
   .key_known   (key_known),
   .key_50hz    (key_50hz),
   .key_invalid (key_invalid)
);

// File: tb/test_lockout_stream_seq.sv
module test_lockout_stream_seq;

   localparam int BIT   = 15;
   localparam int PULSE = 3;
   localparam int SLV   = 4;
   localparam int GAP   = 16;
   localparam logic [59:0] LOCK_DEF = 60'h89E16DF75B4F41B;
   localparam logic [59:0] KEY_TB   = 60'hCED01E11F581A03; // nibble 1 = 3

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l0_in = 1'b0, l1_in = 1'b0;
   logic line0_out, line0_oe, line1_out, line1_oe, slave_rst, mangle_req;
   logic mangle_ack = 1'b0;
   logic [59:0] m_lock_o, m_key_o;
   logic [59:0] m_lock_i = '0, m_key_i = '0;
   logic key_known, key_50hz, key_invalid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [59:0] lockm, keym;

   always #5 clk = ~clk;

   lockout_stream_seq #(
      .BIT_CYC(BIT), .PULSE_CYC(PULSE), .SLV_CYC(SLV), .GAP_CYC(GAP),
      .KEY_INIT(KEY_TB)
   ) i_lockout_stream_seq (
      .clk(clk), .rst_n(rst_n), .line0_in(l0_in), .line1_in(l1_in),
      .line0_out(line0_out), .line0_oe(line0_oe),
      .line1_out(line1_out), .line1_oe(line1_oe),
      .slave_rst(slave_rst), .mangle_req(mangle_req), .mangle_ack(mangle_ack),
      .mangle_lock_o(m_lock_o), .mangle_key_o(m_key_o),
      .mangle_lock_i(m_lock_i), .mangle_key_i(m_key_i),
      .key_known(key_known), .key_50hz(key_50hz), .key_invalid(key_invalid)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   function automatic logic [3:0] nib(input logic [59:0] v, input int p);
      return v[(p-1)*4 +: 4];
   endfunction

   function automatic logic [59:0] setn(input logic [59:0] v, input int p, input logic [3:0] n);
      logic [59:0] r = v;
      r[(p-1)*4 +: 4] = n;
      return r;
   endfunction

   function automatic int idsel(input int k);
      case (k)
         0: return 3;
         1: return 0;
         2: return 1;
         default: return 2;
      endcase
   endfunction

   // R1
   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk({line0_oe, line1_oe, slave_rst, mangle_req, key_known, key_50hz, key_invalid} == 7'b0,
          "R1", {line0_oe, line1_oe, slave_rst, mangle_req, key_known, key_50hz, key_invalid}, 0);
      lockm = LOCK_DEF;
      keym  = KEY_TB;
   endtask

   // R2, R3
   task automatic t_boot;
      l0_in = 1'b0;
      l1_in = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < SLV; i++) begin
         @(negedge clk);
         chk(slave_rst && !line0_oe && !line1_oe, "R2", {slave_rst, line0_oe, line1_oe}, 3'b100);
      end
      for (int i = 0; i < GAP; i++) begin
         @(negedge clk);
         chk(!slave_rst && !line0_oe && !line1_oe, "R2", {slave_rst, line0_oe, line1_oe}, 3'b000);
      end
      for (int c = 0; c < 4 * BIT; c++) begin
         logic e;
         @(negedge clk);
         e = nib(keym, 1)[idsel(c / BIT)] && ((c % BIT) < PULSE);
         chk(line0_oe && !line1_oe && line0_out == e, "R3",
             {line0_oe, line1_oe, line0_out}, {2'b10, e});
      end
   endtask

   task automatic run_pass(input int start, input bit dir, input int inj,
                           input bit detb, input bit first, input string tag);
      for (int p = start; p <= 15; p++) begin
         bit kb;
         bit lb;
         kb = (first && p == 2) ? detb : nib(keym, p)[0];
         lb = nib(lockm, p)[0];
         if (p == inj) kb = ~kb;
         for (int ph = 0; ph < BIT; ph++) begin
            logic e;
            @(negedge clk);
            if (ph == 0) begin
               if (dir) begin l1_in = kb; l0_in = ~kb; end
               else     begin l0_in = kb; l1_in = ~kb; end
            end
            e = lb && (ph < PULSE);
            if (dir)
               chk(line0_oe && !line1_oe && line0_out == e && !line1_out, tag,
                   {line0_oe, line0_out, line1_oe, line1_out}, {2'b10 | e, 2'b00});
            else
               chk(line1_oe && !line0_oe && line1_out == e && !line0_out, tag,
                   {line0_oe, line0_out, line1_oe, line1_out}, {2'b00, 2'b10 | e});
            // R9 request gone once the pass has begun
            if (p == start && ph == 0)
               chk(!mangle_req, "R9", mangle_req, 0);
            // R8 flag rises right after the sample of the corrupted slot
            if (p == inj && ph == 0)
               chk(!key_invalid, "R8", key_invalid, 0);
            if (p == inj && ph == PULSE)
               chk(key_invalid, "R8", key_invalid, 1);
         end
      end
   endtask

   // R9: three acknowledged updates
   task automatic mangle(input logic [59:0] nl, input logic [59:0] nk,
                         input bit chkdet, input logic [3:0] expn2);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(mangle_req && !line0_out && !line1_out, "R9",
             {mangle_req, line0_out, line1_out}, 3'b100);
         if (k == 0 && chkdet)
            chk(nib(m_key_o, 2) == expn2, "R6", nib(m_key_o, 2), expn2);
         m_lock_i   = (k == 2) ? nl : ~nl;
         m_key_i    = (k == 2) ? nk : ~nk;
         mangle_ack = 1'b1;
      end
      @(posedge clk);
      #1 mangle_ack = 1'b0;
      lockm = nl;
      keym  = nk;
   endtask

   task automatic t_first_pass_60;
      // R4, R5, R6: default seeds, detection bit 1
      run_pass(1, 1'b0, 0, 1'b1, 1'b1, "R4/R5");
      chk(key_known && !key_50hz, "R6", {key_known, key_50hz}, 2'b10);
      chk(!key_invalid, "R5", key_invalid, 0);
      mangle(60'h3E71D9B42C685AF, setn(setn(60'hA5C396E17B2D48F, 7, 4'h0), 2, 4'h6), 1'b1, 4'h9);
   endtask

   task automatic t_no_redetect;
      // R7, R11 (nibble 7 = 0 restarts at 1)
      run_pass(1, 1'b0, 0, 1'b0, 1'b0, "R11");
      chk(key_known && !key_50hz, "R7", {key_known, key_50hz}, 2'b10);
      chk(!key_invalid, "R7", key_invalid, 0);
      mangle(60'hD28B4F3A61C07E9, setn(60'h5F0B8D2C3A6E914, 7, 4'h5), 1'b0, 4'h0);
   endtask

   task automatic t_swap_and_mismatch;
      // R10, R11 (start at 5), R8 corrupted slot 9
      run_pass(5, 1'b1, 9, 1'b0, 1'b0, "R10");
      chk(key_invalid, "R8", key_invalid, 1);
      mangle(60'h7A4E2C91B0F8D63, setn(60'h19C7E4A0D35B2F6, 7, 4'h8), 1'b0, 4'h0);
   endtask

   task automatic t_resume_even;
      // R11 start at 8 with line 1 sending; R8 flag kept
      run_pass(8, 1'b0, 0, 1'b0, 1'b0, "R11");
      chk(key_invalid, "R8", key_invalid, 1);
   endtask

   task automatic t_detect_50;
      // R6: detection bit 0
      t_reset();
      t_boot();
      run_pass(1, 1'b0, 0, 1'b0, 1'b1, "R4");
      chk(key_known && key_50hz, "R6", {key_known, key_50hz}, 2'b11);
      chk(!key_invalid, "R6", key_invalid, 0);
      mangle(60'h3E71D9B42C685AF, 60'hA5C396E17B2D48F, 1'b1, 4'h6);
   endtask

   initial begin
      t_reset();
      t_boot();
      t_first_pass_60();
      t_no_redetect();
      t_swap_and_mismatch();
      t_resume_even();
      t_detect_50();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule